// File: doc/BRIEF.md
# Aperture Address Translation Unit

This block sits in the path of device-initiated memory accesses and remaps bus addresses that land inside a configurable aperture window. Each 4 KB page of the window has a 32-bit page entry in a small internal table. The entry carries the physical page frame, up to 40 physical address bits, together with a valid flag and a coherent flag. Addresses outside the window, or any address while translation is switched off, leave the block unchanged with the upper physical byte set to zero.

Software sets up the window through two small registers. The control register holds an enable bit and a 3-bit size order. The base register holds a 15-bit base field in 32 MB units. Both read back, with unimplemented bits reading zero. The page table is loaded through a separate write port. At reset every entry points at a scratch page, so a stray access through an entry that was never written completes and does not fault. A one-entry translation cache holds the most recent table read. It is not updated when the table is written, and software must pulse `flush` after changing entries.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. Only one request is in flight at a time. `req_ready` is high only while the unit is idle and no result is waiting. A result stays on the outputs, unchanged, until `rsp_ready` is seen high at a clock edge.

Top module: `aperture_xlate`

## Requirements
- R1: A control write keeps `cfg_wdata[3:0]`, where bit 0 is the enable and bits 3:1 are the size order. A base write keeps `cfg_wdata[14:0]`. `cfg_ctrl` and `cfg_base` return these values zero-extended to 32 bits. After reset both read zero.
- R2: `ap_size` equals 32 MB shifted left by the size order. The base is the base field shifted left by 25.
- R3: When base plus size is greater than 2^32, `ap_base` reads zero and no address is translated. A base field of zero also disables translation.
- R4: While the enable bit is clear, every request passes through untranslated. Writing the control register with the same order and a different enable leaves `ap_base` and `ap_size` unchanged.
- R5: An address outside [base, base+size) returns `rsp_addr = {8'h00, req_addr}` with `rsp_xlat=0` and `rsp_err=0`, one cycle after acceptance.
- R6: Page entry layout: bits 31:12 hold physical bits 31:12, bits 11:4 hold physical bits 39:32, bit 1 is the coherent flag and bit 0 is the valid flag. A hit on a valid entry returns `{e[11:4], e[31:12], req_addr[11:0]}` with `rsp_xlat=1` and `rsp_coh=e[1]`.
- R7: An in-aperture access to an entry whose valid bit is clear returns `rsp_err=1` with `rsp_addr=0`, `rsp_xlat=0` and `rsp_coh=0`.
- R8: An in-aperture access whose page offset is at or beyond `TBL_DEPTH` returns `rsp_err=1` one cycle after acceptance.
- R9: After reset every table entry is the scratch page entry, which has the valid and coherent flags set. Its frame comes from `SCRATCH_PFN`.
- R10: A lookup that reads the table answers two cycles after acceptance. A lookup of the same page as the cached entry answers in one cycle.
- R11: The cached entry is still used after a table write to that page, until `flush` is pulsed. `flush` clears the cache by the next edge. A lookup accepted in the same cycle as `flush` reads the table.
- R12: `req_ready` is low while a result is pending or a table read is in progress. A result holds stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 base |
| cfg_wdata | input | 15 | Register write data |
| cfg_ctrl | output | 32 | Control register readback |
| cfg_base | output | 32 | Base register readback |
| ap_base | output | 32 | Decoded aperture base (zero if unusable) |
| ap_size | output | 33 | Decoded aperture size in bytes |
| tbl_we | input | 1 | Page table write strobe |
| tbl_idx | input | IDX_W | Page table write index |
| tbl_wdata | input | 32 | Page entry to write |
| flush | input | 1 | Translation cache invalidate strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 32 | Bus address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result ready |
| rsp_addr | output | 40 | Resulting physical address |
| rsp_err | output | 1 | Invalid entry or out-of-table access |
| rsp_xlat | output | 1 | Address was translated |
| rsp_coh | output | 1 | Coherent flag of the used entry |

## Verification
On every cycle the assertions check the stream rules: a held result stays stable, and ready is low while a result is pending. They also check the register readback after a write, and that the decoded size is a single power of two. Further cycle checks cover the pass-through while disabled, the zero address on errors, the fixed table-read latency, and that no cache hit follows a flush. Only the bench scenarios can show the page-entry bit packing, the scratch contents after reset, and the stale cached translation that survives a table write until a flush. The same goes for the boundary decode at exactly 4 GB and the one-versus-two-cycle latency split.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam int PG_SHIFT = 12;
  localparam int PA_W     = 40;
  localparam int BA_W     = 32;
  localparam int PTE_W    = 32;
  localparam int PFN_W    = PA_W - PG_SHIFT;
  localparam int PFN_LO_W = BA_W - PG_SHIFT;
  localparam int PFN_HI_W = PA_W - BA_W;

  typedef logic [PTE_W-1:0] pte_t;

  typedef struct packed {
    logic [PA_W-1:0] addr;
    logic            err;
    logic            xlat;
    logic            coh;
  } apx_rsp_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} apx_st_t;

  function automatic pte_t pte_pack(input logic [PFN_W-1:0] pfn,
                                    input logic coh, input logic vld);
    pte_t e;
    e = '0;
    e[PTE_W-1:PG_SHIFT] = pfn[PFN_LO_W-1:0];
    e[4 +: PFN_HI_W]    = pfn[PFN_W-1:PFN_LO_W];
    e[1] = coh;
    e[0] = vld;
    return e;
  endfunction

  function automatic apx_rsp_t rsp_from_pte(input pte_t e,
                                            input logic [PG_SHIFT-1:0] lo);
    apx_rsp_t r;
    if (e[0]) begin
      r.addr = {e[4 +: PFN_HI_W], e[PTE_W-1:PG_SHIFT], lo};
      r.err  = 1'b0;
      r.xlat = 1'b1;
      r.coh  = e[1];
    end else begin
      r.addr = '0;
      r.err  = 1'b1;
      r.xlat = 1'b0;
      r.coh  = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/apx_regs.sv
module apx_regs #(
  parameter int ORD_W   = 3,
  parameter int BFLD_W  = 15,
  parameter int UNIT_SH = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [BFLD_W-1:0]    cfg_wdata,
  output logic [31:0]          ctrl_rd,
  output logic [31:0]          base_rd,
  output logic                 xlat_en,
  output logic                 ap_ok,
  output logic [31:0]          ap_base,
  output logic [32:0]          ap_size
);
  localparam int CTRL_W = ORD_W + 1;
  localparam int FULL_W = BFLD_W + UNIT_SH + 1;
  localparam logic [FULL_W-1:0] LIMIT = FULL_W'(64'h1_0000_0000);

  logic              en_q;
  logic [ORD_W-1:0]  ord_q;
  logic [BFLD_W-1:0] bfld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ord_q  <= '0;
      bfld_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) bfld_q <= cfg_wdata;
      else {ord_q, en_q} <= cfg_wdata[CTRL_W-1:0];
    end
  end

  assign ctrl_rd = 32'({ord_q, en_q});
  assign base_rd = 32'(bfld_q);

  logic [5:0]        shamt;
  logic [FULL_W-1:0] base_full;
  logic [FULL_W-1:0] end_full;
  logic              over;

  assign shamt     = 6'(UNIT_SH) + 6'(ord_q);
  assign ap_size   = 33'd1 << shamt;
  assign base_full = FULL_W'({bfld_q, {UNIT_SH{1'b0}}});
  assign end_full  = base_full + FULL_W'(ap_size);
  assign over      = end_full > LIMIT;
  assign ap_base   = over ? 32'd0 : base_full[31:0];
  assign ap_ok     = !over && (bfld_q != '0);
  assign xlat_en   = en_q;

  assert_base_rb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel |=> base_rd == 32'($past(cfg_wdata)));

  assert_size_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ap_size) == 1);

  assert_en_keeps_geom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_sel && cfg_wdata[CTRL_W-1:1] == ord_q
      |=> $stable(ap_base) && $stable(ap_size));
endmodule

// File: rtl/apx_table.sv
module apx_table
  import apx_pkg::*;
#(
  parameter int   DEPTH     = 64,
  parameter int   IDX_W     = $clog2(DEPTH),
  parameter pte_t RST_ENTRY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  pte_t             wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output pte_t             rd_data
);
  pte_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) mem_q[g] <= RST_ENTRY;
      else if (wr_en && wr_idx == IDX_W'(g)) mem_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= mem_q[rd_idx];
  end
endmodule

// File: rtl/apx_tlb1.sv
module apx_tlb1
  import apx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill,
  input  logic [IDX_W-1:0] fill_idx,
  input  pte_t             fill_pte,
  input  logic [IDX_W-1:0] look_idx,
  output logic             hit,
  output pte_t             hit_pte
);
  logic             vld_q;
  logic [IDX_W-1:0] tag_q;
  pte_t             pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      pte_q <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (fill) begin
      vld_q <= 1'b1;
      tag_q <= fill_idx;
      pte_q <= fill_pte;
    end
  end

  assign hit     = vld_q && (tag_q == look_idx) && !flush;
  assign hit_pte = pte_q;

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import apx_pkg::*;
#(
  parameter int                  TBL_DEPTH   = 64,
  parameter int                  IDX_W       = $clog2(TBL_DEPTH),
  parameter logic [PFN_W-1:0]    SCRATCH_PFN = 28'h05ABCDE,
  parameter int                  CFG_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [31:0]      cfg_ctrl,
  output logic [31:0]      cfg_base,
  output logic [31:0]      ap_base,
  output logic [32:0]      ap_size,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [31:0]      tbl_wdata,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [39:0]      rsp_addr,
  output logic             rsp_err,
  output logic             rsp_xlat,
  output logic             rsp_coh
);
  localparam pte_t SCRATCH_PTE = pte_pack(SCRATCH_PFN, 1'b1, 1'b1);
  localparam int   PGW         = BA_W - PG_SHIFT;

  logic xlat_en, ap_ok;

  apx_regs #(.BFLD_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rd(cfg_ctrl), .base_rd(cfg_base),
    .xlat_en(xlat_en), .ap_ok(ap_ok), .ap_base(ap_base), .ap_size(ap_size)
  );

  apx_st_t            st_q;
  apx_rsp_t           rsp_q;
  logic               rsp_vld_q;
  logic [PG_SHIFT-1:0] lo_q;
  logic [IDX_W-1:0]   idx_q;

  logic               accept, in_ap, in_tbl, hit, rd_en, fill;
  logic [PGW-1:0]     pg_off;
  logic [IDX_W-1:0]   idx;
  pte_t               hit_pte, rd_pte;

  assign req_ready = (st_q == ST_IDLE) && !rsp_vld_q;
  assign accept    = req_valid && req_ready;
  assign in_ap     = xlat_en && ap_ok
                     && ({1'b0, req_addr} >= {1'b0, ap_base})
                     && ({1'b0, req_addr} < ({1'b0, ap_base} + ap_size));
  assign pg_off    = req_addr[BA_W-1:PG_SHIFT] - ap_base[BA_W-1:PG_SHIFT];
  assign in_tbl    = pg_off < PGW'(TBL_DEPTH);
  assign idx       = pg_off[IDX_W-1:0];
  assign rd_en     = accept && in_ap && in_tbl && !hit;
  assign fill      = (st_q == ST_WAIT) && !flush;

  apx_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .RST_ENTRY(SCRATCH_PTE)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
    .wr_data(tbl_wdata), .rd_en(rd_en), .rd_idx(idx), .rd_data(rd_pte)
  );

  apx_tlb1 #(.IDX_W(IDX_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill(fill),
    .fill_idx(idx_q), .fill_pte(rd_pte), .look_idx(idx),
    .hit(hit), .hit_pte(hit_pte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_q     <= '0;
      rsp_vld_q <= 1'b0;
      lo_q      <= '0;
      idx_q     <= '0;
    end else begin
      if (rsp_vld_q && rsp_ready) rsp_vld_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            lo_q  <= req_addr[PG_SHIFT-1:0];
            idx_q <= idx;
            if (!in_ap) begin
              rsp_vld_q <= 1'b1;
              rsp_q     <= '{addr: {8'h00, req_addr}, err: 1'b0, xlat: 1'b0, coh: 1'b0};
            end else if (!in_tbl) begin
              rsp_vld_q <= 1'b1;
              rsp_q     <= '{addr: '0, err: 1'b1, xlat: 1'b0, coh: 1'b0};
            end else if (hit) begin
              rsp_vld_q <= 1'b1;
              rsp_q     <= rsp_from_pte(hit_pte, req_addr[PG_SHIFT-1:0]);
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          st_q      <= ST_IDLE;
          rsp_vld_q <= 1'b1;
          rsp_q     <= rsp_from_pte(rd_pte, lo_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_vld_q;
  assign rsp_addr  = rsp_q.addr;
  assign rsp_err   = rsp_q.err;
  assign rsp_xlat  = rsp_q.xlat;
  assign rsp_coh   = rsp_q.coh;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err)
      && $stable(rsp_xlat) && $stable(rsp_coh));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_disabled_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlat_en |=> rsp_valid && !rsp_xlat && rsp_addr == {8'h00, $past(req_addr)});

  assert_err_noaddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == '0 && !rsp_xlat && !rsp_coh);

  assert_miss_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WAIT |=> rsp_valid && st_q == ST_IDLE);
endmodule

// File: tb/aperture_xlate_tb.sv
module aperture_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [14:0] cfg_wdata = '0;
  logic [31:0] cfg_ctrl, cfg_base, ap_base;
  logic [32:0] ap_size;
  logic        tbl_we = 1'b0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic [31:0] tbl_wdata = '0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [39:0] rsp_addr;
  logic        rsp_err, rsp_xlat, rsp_coh;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aperture_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
    .ap_base(ap_base), .ap_size(ap_size), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .rsp_xlat(rsp_xlat), .rsp_coh(rsp_coh)
  );

  // addr[80:49] exp[48:9] err[8] xlat[7] coh[6] lat[5:4] req[3:0]
  localparam int NV = 9;
  localparam logic [80:0] VECS [NV] = '{
    {32'h0000_1234, 40'h00_0000_1234, 1'b0, 1'b0, 1'b0, 2'd1, 4'd5},
    {32'h0200_0ABC, 40'h12_3456_7ABC, 1'b0, 1'b1, 1'b1, 2'd2, 4'd6},
    {32'h0200_0FFF, 40'h12_3456_7FFF, 1'b0, 1'b1, 1'b1, 2'd1, 4'd10},
    {32'h0200_1008, 40'h00_8000_1008, 1'b0, 1'b1, 1'b0, 2'd2, 4'd6},
    {32'h0200_2010, 40'h00_0000_0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd7},
    {32'h0200_5444, 40'h05_ABCD_E444, 1'b0, 1'b1, 1'b1, 2'd2, 4'd9},
    {32'h0204_0000, 40'h00_0000_0000, 1'b1, 1'b0, 1'b0, 2'd1, 4'd8},
    {32'h0400_0000, 40'h00_0400_0000, 1'b0, 1'b0, 1'b0, 2'd1, 4'd5},
    {32'h01FF_FFFF, 40'h00_01FF_FFFF, 1'b0, 1'b0, 1'b0, 2'd1, 4'd5}
  };

  function automatic string rname(input int n);
    case (n)
      5: return "R5";  6: return "R6";  7: return "R7";
      8: return "R8";  9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic sel, input logic [14:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tbl_wr(input int i, input logic [31:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = IDX_W'(i); tbl_wdata = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] a, input logic fl,
                        output logic [39:0] ra, output logic re, output logic rx,
                        output logic rc, output int lat);
    @(negedge clk); req_valid = 1'b1; req_addr = a; flush = fl;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0; flush = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    ra = rsp_addr; re = rsp_err; rx = rsp_xlat; rc = rsp_coh;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [39:0] ra; logic re, rx, rc; int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R12)
    chk("R1 ctrl reset", 64'(cfg_ctrl), 64'h0);
    chk("R1 base reset", 64'(cfg_base), 64'h0);
    chk("R12 ready reset", 64'(req_ready), 64'h1);
    chk("R12 valid reset", 64'(rsp_valid), 64'h0);
    chk("R2 size reset", 64'(ap_size), 64'h0200_0000);

    // R1 readback masks
    cfg_wr(1'b0, 15'h7FFF);
    chk("R1 ctrl mask", 64'(cfg_ctrl), 64'hF);
    cfg_wr(1'b1, 15'h7FFF);
    chk("R1 base mask", 64'(cfg_base), 64'h7FFF);

    // R2 / R3 decode
    cfg_wr(1'b0, 15'h0006); cfg_wr(1'b1, 15'h0008);
    chk("R2 size order3", 64'(ap_size), 64'h1000_0000);
    chk("R2 base field8", 64'(ap_base), 64'h1000_0000);
    cfg_wr(1'b1, 15'h0078);
    chk("R3 end at 4G usable", 64'(ap_base), 64'hF000_0000);
    cfg_wr(1'b0, 15'h000E); cfg_wr(1'b1, 15'h0001);
    chk("R2 size order7", 64'(ap_size), 64'h1_0000_0000);
    chk("R3 over 4G base zero", 64'(ap_base), 64'h0);
    cfg_wr(1'b0, 15'h0000); cfg_wr(1'b1, 15'h0080);
    chk("R3 base at 4G zero", 64'(ap_base), 64'h0);

    // program aperture: enable, 32 MB at 0x0200_0000
    cfg_wr(1'b0, 15'h0001); cfg_wr(1'b1, 15'h0001);
    chk("R2 base field1", 64'(ap_base), 64'h0200_0000);
    tbl_wr(0, 32'h3456_7123);
    tbl_wr(1, 32'h8000_1001);
    tbl_wr(2, 32'h1111_1000);
    pulse_flush();

    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i][80:49], 1'b0, ra, re, rx, rc, lat);
      chk(rname(int'(VECS[i][3:0])), {24'h0, ra}, {24'h0, VECS[i][48:9]});
      chk(rname(int'(VECS[i][3:0])), {61'h0, re, rx, rc}, {61'h0, VECS[i][8:6]});
      chk("R10 latency", 64'(lat), 64'(VECS[i][5:4]));
    end

    // R11 stale cache until flush
    do_req(32'h0200_1010, 1'b0, ra, re, rx, rc, lat);
    chk("R11 prime", 64'(lat), 64'd2);
    tbl_wr(1, 32'hCAFE_07F3);
    do_req(32'h0200_1010, 1'b0, ra, re, rx, rc, lat);
    chk("R11 stale addr", {24'h0, ra}, 64'h00_8000_1010);
    chk("R11 stale lat", 64'(lat), 64'd1);
    pulse_flush();
    do_req(32'h0200_1010, 1'b0, ra, re, rx, rc, lat);
    chk("R11 fresh addr", {24'h0, ra}, 64'h7F_CAFE_0010);
    chk("R11 fresh lat", 64'(lat), 64'd2);
    do_req(32'h0200_1020, 1'b1, ra, re, rx, rc, lat);
    chk("R11 same-cycle flush lat", 64'(lat), 64'd2);
    chk("R11 same-cycle flush addr", {24'h0, ra}, 64'h7F_CAFE_0020);

    // R4 enable gating
    cfg_wr(1'b0, 15'h0000);
    chk("R4 base kept", 64'(ap_base), 64'h0200_0000);
    chk("R4 size kept", 64'(ap_size), 64'h0200_0000);
    do_req(32'h0200_0ABC, 1'b0, ra, re, rx, rc, lat);
    chk("R4 pass addr", {24'h0, ra}, 64'h00_0200_0ABC);
    chk("R4 pass xlat", 64'(rx), 64'h0);

    // R3 unusable aperture passes through
    cfg_wr(1'b0, 15'h0003); cfg_wr(1'b1, 15'h007F);
    do_req(32'hFE00_0010, 1'b0, ra, re, rx, rc, lat);
    chk("R3 over pass", {24'h0, ra, rx}, {23'h0, 40'h00_FE00_0010, 1'b0});
    cfg_wr(1'b0, 15'h0001); cfg_wr(1'b1, 15'h0000);
    do_req(32'h0000_0010, 1'b0, ra, re, rx, rc, lat);
    chk("R3 zero base pass", {24'h0, ra, rx}, {23'h0, 40'h00_0000_0010, 1'b0});

    // R12 back-pressure
    cfg_wr(1'b1, 15'h0001);
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0200_0ABC;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 held valid", 64'(rsp_valid), 64'h1);
      chk("R12 held addr", {24'h0, rsp_addr}, 64'h12_3456_7ABC);
      chk("R12 ready low", 64'(req_ready), 64'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", 64'(rsp_valid), 64'h0);
    chk("R12 ready back", 64'(req_ready), 64'h1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule